// File: doc/BRIEF.md
# Instruction Address Translation Buffer

This block turns instruction-fetch virtual addresses into physical addresses. It holds a set-associative table in which every entry is a pair of words: a match word (valid flag, replacement age, virtual tag) and a translate word (physical page, cache-inhibit flag, supervisor and user execute permissions). Software loads entries one word at a time through a write port and can read any word back. A fetch request looks up the set picked by the page number, reports a hit with the physical address, or reports a miss with the faulting virtual address. There is no hardware refill. When translation is off the address passes through unchanged.

Each hit ages the other ways of the set and reloads the age of the hit way, so that refill software can pick a victim. Hit and miss responses come out after separate configurable delays. A probe port does the same lookup for a debugger, with no effect on ages and no fault reporting. A constant configuration word reports the geometry.

Top module: `itlb_xlate`

## Requirements
- R1: With `xlat_en` low, or with parameter `PRESENT` zero, a fetch response carries `resp_pa` equal to the virtual address, `resp_hit` and `resp_miss` low, and `resp_ci` high exactly when the address is at or above 0x80000000.
- R2: The set index is virtual address bits [PAGE_LOG2 +: log2(SETS)]. A way hits only if its valid flag is set and match-word bits [31:PAGE_LOG2+log2(SETS)] equal the same bits of the address.
- R3: When several ways of a set hit, the lowest-numbered way supplies the translation.
- R4: The age of a way is match-word bits [6 +: AGE_W]. On a fetch hit each way of the indexed set with a nonzero age is decremented by one, then the hit way's age is ORed with (SETS-1) cut to AGE_W bits.
- R5: On a hit, `resp_pa` is translate-word bits [31:PAGE_LOG2] joined with the address bits below PAGE_LOG2, and `resp_ci` is translate-word bit 1.
- R6: On a hit, `resp_fault` is raised when `sup_mode` is high and translate-word bit 6 is clear, or when `sup_mode` is low and translate-word bit 7 is clear.
- R7: A miss raises `resp_miss` with `resp_va` equal to the fetch address, `resp_pa` zero and `resp_ci` low, and neither allocates an entry nor changes any age.
- R8: `probe_pa`, one cycle after `probe_va`, is the probe address when translation is off, the translated address on a permitted hit, and zero on a miss or a permission failure; probes change no age.
- R9: `cfg_word` bits [6:3] hold log2(SETS) and bits [1:0] hold WAYS-1; all other bits are zero.
- R10: A fetch response appears HIT_DLY+1 cycles after the request on a hit, MISS_DLY+1 cycles after it on a miss, and one cycle after it when translation is off; `resp_valid` is high for one cycle.
- R11: Reset clears every valid flag and holds `resp_valid` low.
- R12: A write with `wr_sel` low stores a match word, with `wr_sel` high a translate word; bit 0 of a match word is the valid flag; a read returns the stored word on `rd_data` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Fetch lookup request, one cycle |
| fetch_va | input | 32 | Fetch virtual address |
| xlat_en | input | 1 | Translation enable |
| sup_mode | input | 1 | Supervisor mode |
| wr_en | input | 1 | Entry word write strobe |
| wr_way | input | WAY_W | Way of the word written |
| wr_set | input | SET_W | Set of the word written |
| wr_sel | input | 1 | 0 match word, 1 translate word |
| wr_data | input | 32 | Word written |
| rd_way | input | WAY_W | Way of the word read |
| rd_set | input | SET_W | Set of the word read |
| rd_sel | input | 1 | 0 match word, 1 translate word |
| rd_data | output | 32 | Word read, registered |
| probe_va | input | 32 | Debugger lookup address |
| probe_pa | output | 32 | Debugger lookup result, registered |
| resp_valid | output | 1 | Fetch response strobe |
| resp_hit | output | 1 | Translation found |
| resp_miss | output | 1 | No translation found |
| resp_fault | output | 1 | Execute permission missing |
| resp_ci | output | 1 | Cache inhibit |
| resp_pa | output | 32 | Physical address |
| resp_va | output | 32 | Virtual address of the request |
| cfg_word | output | 8 | Geometry report |

## Verification
The assertions take for granted that no new fetch arrives while a delayed response is still pending, and that a software write never lands on the entry a fetch hit is ageing in the same cycle; the stimulus waits for each response before the next request and keeps table loading apart from fetches. They also assume way and set numbers on the write port stay inside the configured geometry, which the stimulus respects by only addressing existing ways and sets.

// File: rtl/itlb_pkg.sv
package itlb_pkg;
  localparam int VA_W      = 32;
  // match word layout
  localparam int MV_BIT    = 0;   // valid flag
  localparam int AGE_LSB   = 6;   // replacement age field base
  // translate word layout
  localparam int TCI_BIT   = 1;   // cache inhibit
  localparam int TSX_BIT   = 6;   // supervisor execute allowed
  localparam int TUX_BIT   = 7;   // user execute allowed

  typedef struct packed {
    logic            hit;
    logic            miss;
    logic            fault;
    logic            ci;
    logic [VA_W-1:0] pa;
    logic [VA_W-1:0] va;
  } xl_res_t;
endpackage

// File: rtl/itlb_store.sv
module itlb_store import itlb_pkg::*; #(
  parameter int SETS  = 16,
  parameter int WAYS  = 2,
  parameter int AGE_W = 2,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [WAY_W-1:0]          wr_way,
  input  logic [SET_W-1:0]          wr_set,
  input  logic                      wr_sel,
  input  logic [VA_W-1:0]           wr_data,
  input  logic                      upd_en,
  input  logic [WAY_W-1:0]          upd_way,
  input  logic [SET_W-1:0]          upd_set,
  input  logic [WAY_W-1:0]          rd_way,
  input  logic [SET_W-1:0]          rd_set,
  input  logic                      rd_sel,
  output logic [VA_W-1:0]           rd_data,
  input  logic [SET_W-1:0]          fa_set,
  output logic [WAYS-1:0][VA_W-1:0] fa_m,
  output logic [WAYS-1:0][VA_W-1:0] fa_t,
  output logic [WAYS-1:0]           fa_v,
  input  logic [SET_W-1:0]          fb_set,
  output logic [WAYS-1:0][VA_W-1:0] fb_m,
  output logic [WAYS-1:0][VA_W-1:0] fb_t,
  output logic [WAYS-1:0]           fb_v
);
  localparam int RELOAD_I = (SETS - 1) % (1 << AGE_W);
  localparam logic [AGE_W-1:0] RELOAD = AGE_W'(RELOAD_I);

  logic [VA_W-1:0] mtab [WAYS][SETS];
  logic [VA_W-1:0] ttab [WAYS][SETS];
  logic [SETS-1:0] vld  [WAYS];
  logic [AGE_W-1:0] age_nxt [WAYS];

  // age decrement then reload of the hit way
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      age_nxt[w] = mtab[w][upd_set][AGE_LSB +: AGE_W];
      if (age_nxt[w] != '0) age_nxt[w] = age_nxt[w] - 1'b1;
      if (upd_way == WAY_W'(w)) age_nxt[w] = age_nxt[w] | RELOAD;
    end
  end

  // table words: no reset, so they map onto plain memory
  always_ff @(posedge clk) begin
    if (upd_en) begin
      for (int w = 0; w < WAYS; w++)
        mtab[w][upd_set][AGE_LSB +: AGE_W] <= age_nxt[w];
    end
    if (wr_en && !wr_sel) mtab[wr_way][wr_set] <= wr_data;
    if (wr_en &&  wr_sel) ttab[wr_way][wr_set] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < WAYS; w++) vld[w] <= '0;
    end else if (wr_en && !wr_sel) begin
      vld[wr_way][wr_set] <= wr_data[MV_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rd_sel) rd_data <= ttab[rd_way][rd_set];
    else        rd_data <= {mtab[rd_way][rd_set][VA_W-1:1], vld[rd_way][rd_set]};
  end

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      fa_m[w] = mtab[w][fa_set];
      fa_t[w] = ttab[w][fa_set];
      fa_v[w] = vld[w][fa_set];
      fb_m[w] = mtab[w][fb_set];
      fb_t[w] = ttab[w][fb_set];
      fb_v[w] = vld[w][fb_set];
    end
  end

  AST_HIT_AGE_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (upd_en && !wr_en) |=> ((mtab[$past(upd_way)][$past(upd_set)][AGE_LSB +: AGE_W] & RELOAD) == RELOAD)); // R4

  AST_RESET_INVALID: assert property (@(posedge clk)
    $past(rst) |-> (vld[0] == '0)); // R11
endmodule

// File: rtl/itlb_lookup.sv
module itlb_lookup import itlb_pkg::*; #(
  parameter int PAGE_LOG2 = 13,
  parameter int SET_W     = 4,
  parameter int WAYS      = 2,
  localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int TAG_LSB  = PAGE_LOG2 + SET_W
) (
  input  logic [VA_W-1:0]           va,
  input  logic                      sup,
  input  logic [WAYS-1:0][VA_W-1:0] mword,
  input  logic [WAYS-1:0][VA_W-1:0] tword,
  input  logic [WAYS-1:0]           vld,
  output logic                      hit,
  output logic [WAY_W-1:0]          hit_way,
  output logic [VA_W-1:0]           pa,
  output logic                      ci,
  output logic                      perm_ok
);
  logic [VA_W-1:0] sel_t;
  logic            unused_lk;

  // scan from the top so the lowest matching way is the last to win
  always_comb begin
    hit     = 1'b0;
    hit_way = '0;
    sel_t   = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (vld[w] && (mword[w][VA_W-1:TAG_LSB] == va[VA_W-1:TAG_LSB])) begin
        hit     = 1'b1;
        hit_way = WAY_W'(w);
        sel_t   = tword[w];
      end
    end
  end

  assign pa      = {sel_t[VA_W-1:PAGE_LOG2], va[PAGE_LOG2-1:0]};
  assign ci      = sel_t[TCI_BIT];
  assign perm_ok = sup ? sel_t[TSX_BIT] : sel_t[TUX_BIT];
  assign unused_lk = ^{mword, sel_t, va[TAG_LSB-1:PAGE_LOG2]};
endmodule

// File: rtl/itlb_resp_timer.sv
module itlb_resp_timer import itlb_pkg::*; #(
  parameter int HIT_DLY  = 1,
  parameter int MISS_DLY = 3,
  localparam int MAXD    = (HIT_DLY > MISS_DLY) ? HIT_DLY : MISS_DLY,
  localparam int CNT_W   = (MAXD > 0) ? $clog2(MAXD + 1) : 1
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    fetch,
  input  xl_res_t res_in,
  output logic    resp_valid,
  output xl_res_t resp
);
  localparam logic [CNT_W-1:0] HD = CNT_W'(HIT_DLY);
  localparam logic [CNT_W-1:0] MD = CNT_W'(MISS_DLY);

  logic             pend;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] dly;

  assign dly = res_in.hit ? HD : (res_in.miss ? MD : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend       <= 1'b0;
      cnt        <= '0;
      resp_valid <= 1'b0;
      resp       <= '0;
    end else begin
      resp_valid <= 1'b0;
      if (fetch) begin
        resp <= res_in;
        if (dly == '0) resp_valid <= 1'b1;
        else begin
          pend <= 1'b1;
          cnt  <= dly;
        end
      end else if (pend) begin
        cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          resp_valid <= 1'b1;
          pend       <= 1'b0;
        end
      end
    end
  end

  AST_NO_FETCH_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    fetch |-> !pend); // R10
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> !(resp.hit && resp.miss)); // R7
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !fetch) |=> !resp_valid); // R10
endmodule

// File: rtl/itlb_xlate.sv
module itlb_xlate import itlb_pkg::*; #(
  parameter int PAGE_LOG2 = 13,
  parameter int SETS      = 16,
  parameter int WAYS      = 2,
  parameter int AGE_W     = 2,
  parameter int HIT_DLY   = 1,
  parameter int MISS_DLY  = 3,
  parameter bit PRESENT   = 1'b1,
  localparam int SET_W    = $clog2(SETS),
  localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fetch_valid,
  input  logic [31:0]      fetch_va,
  input  logic             xlat_en,
  input  logic             sup_mode,
  input  logic             wr_en,
  input  logic [WAY_W-1:0] wr_way,
  input  logic [SET_W-1:0] wr_set,
  input  logic             wr_sel,
  input  logic [31:0]      wr_data,
  input  logic [WAY_W-1:0] rd_way,
  input  logic [SET_W-1:0] rd_set,
  input  logic             rd_sel,
  output logic [31:0]      rd_data,
  input  logic [31:0]      probe_va,
  output logic [31:0]      probe_pa,
  output logic             resp_valid,
  output logic             resp_hit,
  output logic             resp_miss,
  output logic             resp_fault,
  output logic             resp_ci,
  output logic [31:0]      resp_pa,
  output logic [31:0]      resp_va,
  output logic [7:0]       cfg_word
);
  logic                      xl_on;
  logic [WAYS-1:0][VA_W-1:0] fa_m, fa_t, fb_m, fb_t;
  logic [WAYS-1:0]           fa_v, fb_v;
  logic                      f_hit, f_ci, f_perm;
  logic [WAY_W-1:0]          f_way;
  logic [VA_W-1:0]           f_pa;
  logic                      p_hit, p_ci, p_perm;
  logic [WAY_W-1:0]          p_way;
  logic [VA_W-1:0]           p_pa;
  xl_res_t                   res_in, resp;
  logic                      unused_top;

  assign xl_on = xlat_en && PRESENT;

  itlb_store #(.SETS(SETS), .WAYS(WAYS), .AGE_W(AGE_W)) u_store (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_way(wr_way), .wr_set(wr_set), .wr_sel(wr_sel), .wr_data(wr_data),
    .upd_en(fetch_valid && xl_on && f_hit), .upd_way(f_way),
    .upd_set(fetch_va[PAGE_LOG2 +: SET_W]),
    .rd_way(rd_way), .rd_set(rd_set), .rd_sel(rd_sel), .rd_data(rd_data),
    .fa_set(fetch_va[PAGE_LOG2 +: SET_W]), .fa_m(fa_m), .fa_t(fa_t), .fa_v(fa_v),
    .fb_set(probe_va[PAGE_LOG2 +: SET_W]), .fb_m(fb_m), .fb_t(fb_t), .fb_v(fb_v)
  );

  itlb_lookup #(.PAGE_LOG2(PAGE_LOG2), .SET_W(SET_W), .WAYS(WAYS)) u_fetch_lk (
    .va(fetch_va), .sup(sup_mode), .mword(fa_m), .tword(fa_t), .vld(fa_v),
    .hit(f_hit), .hit_way(f_way), .pa(f_pa), .ci(f_ci), .perm_ok(f_perm)
  );

  itlb_lookup #(.PAGE_LOG2(PAGE_LOG2), .SET_W(SET_W), .WAYS(WAYS)) u_probe_lk (
    .va(probe_va), .sup(sup_mode), .mword(fb_m), .tword(fb_t), .vld(fb_v),
    .hit(p_hit), .hit_way(p_way), .pa(p_pa), .ci(p_ci), .perm_ok(p_perm)
  );

  always_comb begin
    res_in.va    = fetch_va;
    res_in.hit   = xl_on && f_hit;
    res_in.miss  = xl_on && !f_hit;
    res_in.fault = xl_on && f_hit && !f_perm;
    res_in.ci    = xl_on ? (f_hit && f_ci) : fetch_va[31];
    res_in.pa    = !xl_on ? fetch_va : (f_hit ? f_pa : '0);
  end

  itlb_resp_timer #(.HIT_DLY(HIT_DLY), .MISS_DLY(MISS_DLY)) u_timer (
    .clk(clk), .rst(rst), .fetch(fetch_valid), .res_in(res_in),
    .resp_valid(resp_valid), .resp(resp)
  );

  always_ff @(posedge clk) begin
    if (rst)                  probe_pa <= '0;
    else if (!xl_on)          probe_pa <= probe_va;
    else if (p_hit && p_perm) probe_pa <= p_pa;
    else                      probe_pa <= '0;
  end

  assign resp_hit   = resp.hit;
  assign resp_miss  = resp.miss;
  assign resp_fault = resp.fault;
  assign resp_ci    = resp.ci;
  assign resp_pa    = resp.pa;
  assign resp_va    = resp.va;
  assign cfg_word   = {1'b0, 4'(SET_W), 1'b0, 2'(WAYS - 1)};
  assign unused_top = ^{p_way, p_ci};

  AST_BYPASS_IDENT: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_hit && !resp_miss) |-> (resp_pa == resp_va && resp_ci == resp_va[31])); // R1
  AST_FAULT_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_fault) |-> resp_hit); // R6
  AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_miss) |-> (resp_pa == '0 && !resp_ci && !resp_fault)); // R7
  AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
    $past(rst) |-> !resp_valid); // R11
endmodule

// File: tb/itlb_xlate_tb.sv
`timescale 1ns/1ps
module itlb_xlate_tb;
  localparam int HIT_DLY  = 1;
  localparam int MISS_DLY = 3;

  logic        clk = 1'b0;
  logic        rst;
  logic        fetch_valid, xlat_en, sup_mode, wr_en, wr_sel, rd_sel;
  logic [31:0] fetch_va, wr_data, probe_va;
  logic        wr_way, rd_way;
  logic [3:0]  wr_set, rd_set;
  logic [31:0] rd_data, probe_pa, resp_pa, resp_va;
  logic        resp_valid, resp_hit, resp_miss, resp_fault, resp_ci;
  logic [7:0]  cfg_word;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  itlb_xlate #(.PAGE_LOG2(13), .SETS(16), .WAYS(2), .AGE_W(2),
               .HIT_DLY(HIT_DLY), .MISS_DLY(MISS_DLY), .PRESENT(1'b1)) u_dut (
    .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_va(fetch_va),
    .xlat_en(xlat_en), .sup_mode(sup_mode),
    .wr_en(wr_en), .wr_way(wr_way), .wr_set(wr_set), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_way(rd_way), .rd_set(rd_set), .rd_sel(rd_sel), .rd_data(rd_data),
    .probe_va(probe_va), .probe_pa(probe_pa),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_miss(resp_miss),
    .resp_fault(resp_fault), .resp_ci(resp_ci), .resp_pa(resp_pa), .resp_va(resp_va),
    .cfg_word(cfg_word)
  );

  always #4 clk = ~clk;

  typedef struct packed {
    logic [31:0] va;
    logic        xen;
    logic        sup;
    logic        hit;
    logic        miss;
    logic        fault;
    logic        ci;
    logic [31:0] pa;
  } vec_t;

  // va, xen, sup, hit, miss, fault, ci, pa
  localparam vec_t VEC [9] = '{
    '{32'h0122_4ABC, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 32'h3456_0ABC}, // R5 R2
    '{32'h0122_4ABC, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 32'h3456_0ABC}, // R6 user
    '{32'h00AA_5FFF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h7000_3FFF}, // R5 way1
    '{32'h00AA_5FFF, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 32'h7000_3FFF}, // R6 sup
    '{32'h0ABC_4000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_0000}, // R7 tag
    '{32'h0122_6000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_0000}, // R2 set
    '{32'h0020_A010, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h1111_0010}, // R3
    '{32'h8000_0004, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 32'h8000_0004}, // R1 high
    '{32'h7FFF_FFFC, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h7FFF_FFFC}  // R1 low
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic way, input logic [3:0] set, input logic sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_way = way; wr_set = set; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic way, input logic [3:0] set, input logic sel, output logic [31:0] d);
    @(negedge clk);
    rd_way = way; rd_set = set; rd_sel = sel;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic fetch(input logic [31:0] va, input logic xen, input logic sup, output int lat);
    @(negedge clk);
    fetch_valid = 1'b1; fetch_va = va; xlat_en = xen; sup_mode = sup;
    @(negedge clk);
    fetch_valid = 1'b0;
    lat = 1;
    while (!resp_valid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic probe(input logic [31:0] va, input logic xen, input logic sup, output logic [31:0] pa);
    @(negedge clk);
    probe_va = va; xlat_en = xen; sup_mode = sup;
    @(negedge clk);
    pa = probe_pa;
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [31:0] d;
    int lat;
    int exp_lat;
    rst = 1'b1; fetch_valid = 1'b0; fetch_va = '0; xlat_en = 1'b1; sup_mode = 1'b1;
    wr_en = 1'b0; wr_way = 1'b0; wr_set = '0; wr_sel = 1'b0; wr_data = '0;
    rd_way = 1'b0; rd_set = '0; rd_sel = 1'b0; probe_va = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(resp_valid == 1'b0, "R11", "resp_valid in reset", {31'b0, resp_valid}, 32'h0);
    rst = 1'b0;
    chk(cfg_word == 8'h21, "R9", "cfg_word", {24'b0, cfg_word}, 32'h21);

    // R11: table empty after reset
    fetch(32'h0122_4ABC, 1'b1, 1'b1, lat);
    chk(resp_valid && resp_miss && !resp_hit, "R11", "miss after reset",
        {30'b0, resp_hit, resp_miss}, 32'h1);

    // load entries
    wr(1'b0, 4'd2, 1'b0, 32'h0122_0001); wr(1'b0, 4'd2, 1'b1, 32'h3456_0042);
    wr(1'b1, 4'd2, 1'b0, 32'h00AA_0001); wr(1'b1, 4'd2, 1'b1, 32'h7000_2080);
    wr(1'b0, 4'd5, 1'b0, 32'h0020_0001); wr(1'b0, 4'd5, 1'b1, 32'h1111_00C0);
    wr(1'b1, 4'd5, 1'b0, 32'h0020_0001); wr(1'b1, 4'd5, 1'b1, 32'h2222_00C0);
    wr(1'b0, 4'd7, 1'b0, 32'h0040_0041); wr(1'b0, 4'd7, 1'b1, 32'h0900_00C0);
    wr(1'b1, 4'd7, 1'b0, 32'h0042_0081); wr(1'b1, 4'd7, 1'b1, 32'h0A00_00C0);

    // R12 readback
    rd(1'b0, 4'd2, 1'b1, d);
    chk(d == 32'h3456_0042, "R12", "translate readback", d, 32'h3456_0042);
    rd(1'b1, 4'd5, 1'b0, d);
    chk(d == 32'h0020_0001, "R12", "match readback", d, 32'h0020_0001);

    // vector table
    for (int i = 0; i < 9; i++) begin
      fetch(VEC[i].va, VEC[i].xen, VEC[i].sup, lat);
      exp_lat = VEC[i].hit ? HIT_DLY + 1 : (VEC[i].miss ? MISS_DLY + 1 : 1);
      chk(resp_valid && resp_hit == VEC[i].hit && resp_miss == VEC[i].miss &&
          resp_fault == VEC[i].fault && resp_ci == VEC[i].ci,
          "R1/R2/R3/R5/R6 flags", $sformatf("vector %0d hit,miss,fault,ci", i),
          {28'b0, resp_hit, resp_miss, resp_fault, resp_ci},
          {28'b0, VEC[i].hit, VEC[i].miss, VEC[i].fault, VEC[i].ci});
      chk(resp_pa == VEC[i].pa, "R5", $sformatf("vector %0d pa", i), resp_pa, VEC[i].pa);
      chk(lat == exp_lat, "R10", $sformatf("vector %0d latency", i), lat, exp_lat);
      if (VEC[i].miss)
        chk(resp_va == VEC[i].va, "R7", $sformatf("vector %0d miss va", i), resp_va, VEC[i].va);
    end

    // R7: misses allocated nothing; R4: ages from the four set-2 hits
    rd(1'b0, 4'd2, 1'b0, d);
    chk(d == 32'h0122_0041, "R4", "set2 way0 age", d, 32'h0122_0041);
    rd(1'b1, 4'd2, 1'b0, d);
    chk(d == 32'h00AA_00C1, "R7", "set2 way1 unchanged by miss", d, 32'h00AA_00C1);
    fetch(32'h0ABC_4000, 1'b1, 1'b1, lat);
    chk(resp_miss, "R7", "repeat miss not allocated", {31'b0, resp_miss}, 32'h1);

    // R4 age sequence on set 7
    fetch(32'h0042_E000, 1'b1, 1'b1, lat);
    rd(1'b0, 4'd7, 1'b0, d);
    chk(d == 32'h0040_0001, "R4", "way0 decremented", d, 32'h0040_0001);
    rd(1'b1, 4'd7, 1'b0, d);
    chk(d == 32'h0042_00C1, "R4", "way1 reloaded", d, 32'h0042_00C1);
    fetch(32'h0040_E000, 1'b1, 1'b1, lat);
    chk(resp_pa == 32'h0900_0000, "R5", "set7 way0 pa", resp_pa, 32'h0900_0000);
    rd(1'b0, 4'd7, 1'b0, d);
    chk(d == 32'h0040_00C1, "R4", "way0 reloaded", d, 32'h0040_00C1);
    rd(1'b1, 4'd7, 1'b0, d);
    chk(d == 32'h0042_0081, "R4", "way1 decremented", d, 32'h0042_0081);

    // R8 probe port
    probe(32'h0122_4ABC, 1'b1, 1'b1, d);
    chk(d == 32'h3456_0ABC, "R8", "probe permitted hit", d, 32'h3456_0ABC);
    probe(32'h0122_4ABC, 1'b1, 1'b0, d);
    chk(d == 32'h0, "R8", "probe permission fail", d, 32'h0);
    probe(32'h0ABC_4000, 1'b1, 1'b1, d);
    chk(d == 32'h0, "R8", "probe miss", d, 32'h0);
    probe(32'hC000_1234, 1'b0, 1'b1, d);
    chk(d == 32'hC000_1234, "R8", "probe translation off", d, 32'hC000_1234);
    probe(32'h0042_E000, 1'b1, 1'b1, d);
    chk(d == 32'h0A00_0000, "R8", "probe set7 way1", d, 32'h0A00_0000);
    rd(1'b1, 4'd7, 1'b0, d);
    chk(d == 32'h0042_0081, "R8", "probe leaves age", d, 32'h0042_0081);
    rd(1'b0, 4'd7, 1'b0, d);
    chk(d == 32'h0040_00C1, "R8", "probe leaves hit-way age", d, 32'h0040_00C1);

    // R12 invalidation by match write with bit 0 clear
    wr(1'b0, 4'd5, 1'b0, 32'h0020_0000);
    fetch(32'h0020_A010, 1'b1, 1'b1, lat);
    chk(resp_hit && resp_pa == 32'h2222_0010, "R12", "invalidated way0, way1 serves",
        resp_pa, 32'h2222_0010);

    report();
  end
endmodule